// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a 24-bit position count from an incremental encoder. Two phase inputs and an index input are first resynchronised to the core clock. They are then decoded according to a selectable scheme: step-and-direction, or single, double or quadruple edge quadrature. The resulting up/down steps move a counter whose behaviour at its boundaries depends on a selectable boundary mode. In two of those modes the preset value serves as the ceiling.

A register front end supplies the configuration as static levels and issues single-cycle strobes:
- a preset-load strobe,
- an output-latch strobe,
- a flag-clear strobe.

The index input can reload the preset. It does this either on its active edge, or, in synchronous mode, when the phases enter the both-high state while the index sits at its active level. Synchronous mode is honoured only under a quadrature scheme. Sticky flags report wrap-around, index events and illegal phase transitions for the front end to read or to turn into interrupts.

Top module: `quad_count_core`

## Requirements
- R1: After a synchronous reset the count is 0; the carry, borrow, sign, index and error flags are 0; the direction flag is 1 (up).
- R2: With `dec_sel`=0 (step/direction), each rising edge of `enc_a` counts once, up when `enc_b` is 1 and down when it is 0. Falling edges of `enc_a` and any change of `enc_b` do not count.
- R3: With `dec_sel`=1 (single-edge quadrature), a rising `enc_a` while `enc_b` is 0 counts up, and a falling `enc_a` while `enc_b` is 0 counts down. No other edge counts, so a full phase cycle moves the count by one.
- R4: With `dec_sel`=2 (double-edge quadrature), both edges of `enc_a` count. A rising edge counts up when `enc_b` is 0 and down when it is 1; a falling edge does the reverse. A full cycle moves the count by two.
- R5: With `dec_sel`=3 (quadruple-edge quadrature), every edge of either phase counts, with the up sequence (a,b) = 00,10,11,01. A full cycle moves the count by four. `up_flag` holds the direction of the most recent step.
- R6: While `ab_en` is 0, phase edges leave the count unchanged.
- R7: With `cnt_sel`=0 (free-running), an up step at 0xFFFFFF gives 0 and sets `carry_flag`, and a down step at 0 gives 0xFFFFFF and sets `borrow_flag`. `sign_flag` is set by a borrow and cleared by a carry.
- R8: With `cnt_sel`=1 (clamped), an up step at or above the preset holds the count and sets carry, and a down step at 0 holds the count and sets borrow.
- R9: With `cnt_sel`=2 (one-shot), the count wraps as in R7 and then freezes. It resumes only after a preset load by strobe or by index.
- R10: With `cnt_sel`=3 (modulo), the count runs from 0 to the preset. An up step at the preset gives 0 with carry, and a down step at 0 gives the preset with borrow.
- R11: `load_stb` copies `preset_val` into the count on the next edge, overriding any step in that cycle. `latch_stb` copies the current count to `latch_val`. `cmp_flag` is 1 exactly when the count equals `preset_val`.
- R12: In edge index mode, the active index edge is rising when `idx_pos_pol`=1 and falling when it is 0. An active edge sets `idx_flag`. When `idx_preset_n`=0 it also loads the preset, and the load takes priority over a coincident step. When `idx_preset_n`=1 the count is untouched.
- R13: With `idx_sync_req`=1 under a quadrature scheme, the index event fires when the phases enter the state a=1,b=1 while the index is at its active level. Index edges alone then do nothing. Under step/direction the request is ignored and edge index mode applies.
- R14: Under a quadrature scheme with `ab_en`=1, a cycle in which both phases change sets `err_flag` and does not count. `clr_stb` clears the carry, borrow, sign, index and error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| dec_sel | input | 2 | Decode scheme: 0 step/dir, 1 x1, 2 x2, 3 x4 |
| cnt_sel | input | 2 | Boundary mode: 0 free, 1 clamped, 2 one-shot, 3 modulo |
| ab_en | input | 1 | 1 lets phase edges count |
| idx_preset_n | input | 1 | 0 makes an index event load the preset |
| idx_sync_req | input | 1 | Requests synchronous index mode |
| idx_pos_pol | input | 1 | Index active level: 1 high, 0 low |
| preset_val | input | 24 | Preset and ceiling value |
| load_stb | input | 1 | Load preset into count |
| latch_stb | input | 1 | Copy count to latch output |
| clr_stb | input | 1 | Clear sticky flags |
| count_val | output | 24 | Current count |
| latch_val | output | 24 | Latched count |
| carry_flag | output | 1 | Sticky overflow / upper boundary hit |
| borrow_flag | output | 1 | Sticky underflow / lower boundary hit |
| cmp_flag | output | 1 | Count equals preset |
| sign_flag | output | 1 | Set on borrow, cleared on carry |
| up_flag | output | 1 | Direction of last step |
| idx_flag | output | 1 | Sticky index event |
| err_flag | output | 1 | Sticky illegal transition |

## Verification
Two functions can collide in one cycle: an index-triggered preset load and a count step. In synchronous index mode they coincide by construction, because the phase transition into the both-high state is itself a step. The bench holds the index at its active level and moves the phases 10 to 11 under x4 decode. It then expects the count to equal the preset exactly, not the preset plus one. Subsequent steps must count onward from the preset, and moves after the index goes inactive must count normally.

// File: rtl/qc_pkg.sv
package qc_pkg;

    typedef enum logic [1:0] {
        DEC_STEPDIR = 2'd0,
        DEC_X1      = 2'd1,
        DEC_X2      = 2'd2,
        DEC_X4      = 2'd3
    } dec_mode_e;

    typedef enum logic [1:0] {
        BND_FREE    = 2'd0,
        BND_CLAMP   = 2'd1,
        BND_ONESHOT = 2'd2,
        BND_MODULO  = 2'd3
    } bnd_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic bad;
    } step_t;

    function automatic logic dec_is_quad(dec_mode_e m);
        return m != DEC_STEPDIR;
    endfunction

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prv
);
    logic [WIDTH-1:0] meta;

    // Plain shift chain; it fills while reset is held.
    always_ff @(posedge clk) begin
        meta <= raw;
        cur  <= meta;
        prv  <= cur;
    end
endmodule

// File: rtl/qc_decode.sv
module qc_decode
    import qc_pkg::*;
(
    input  logic      a_s,
    input  logic      b_s,
    input  logic      a_d,
    input  logic      b_d,
    input  dec_mode_e dec,
    input  logic      gate,
    output step_t     stp
);
    logic a_rise, a_fall, b_rise, b_fall, both;

    assign a_rise = a_s & ~a_d;
    assign a_fall = ~a_s & a_d;
    assign b_rise = b_s & ~b_d;
    assign b_fall = ~b_s & b_d;
    assign both   = (a_s ^ a_d) & (b_s ^ b_d);

    always_comb begin
        stp = '0;
        if (gate) begin
            if (dec_is_quad(dec) && both) begin
                stp.bad = 1'b1;
            end else begin
                unique case (dec)
                    DEC_STEPDIR: begin
                        stp.up = a_rise & b_s;
                        stp.dn = a_rise & ~b_s;
                    end
                    DEC_X1: begin
                        stp.up = a_rise & ~b_s;
                        stp.dn = a_fall & ~b_s;
                    end
                    DEC_X2: begin
                        stp.up = (a_rise & ~b_s) | (a_fall & b_s);
                        stp.dn = (a_rise & b_s) | (a_fall & ~b_s);
                    end
                    default: begin
                        stp.up = (a_rise & ~b_s) | (a_fall & b_s) |
                                 (b_rise & a_s) | (b_fall & ~a_s);
                        stp.dn = (a_rise & b_s) | (a_fall & ~b_s) |
                                 (b_rise & ~a_s) | (b_fall & a_s);
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/qc_index.sv
module qc_index
    import qc_pkg::*;
(
    input  logic      idx_s,
    input  logic      idx_d,
    input  logic      a_s,
    input  logic      b_s,
    input  logic      a_d,
    input  logic      b_d,
    input  logic      pos_pol,
    input  logic      sync_req,
    input  dec_mode_e dec,
    output logic      evt
);
    logic sync_eff, lvl_act, edge_act, ab_enter;

    assign sync_eff = sync_req & dec_is_quad(dec);
    assign lvl_act  = pos_pol ? idx_s : ~idx_s;
    assign edge_act = pos_pol ? (idx_s & ~idx_d) : (~idx_s & idx_d);
    assign ab_enter = (a_s & b_s) & ~(a_d & b_d);
    assign evt      = sync_eff ? (lvl_act & ab_enter) : edge_act;
endmodule

// File: rtl/qc_count.sv
module qc_count
    import qc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  bnd_mode_e        bmode,
    input  logic [CNT_W-1:0] preset,
    input  step_t            stp,
    input  logic             load_stb,
    input  logic             idx_evt,
    input  logic             idx_load_en,
    input  logic             latch_stb,
    input  logic             clr_stb,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] latch,
    output logic             carry_f,
    output logic             borrow_f,
    output logic             sign_f,
    output logic             up_f,
    output logic             idx_f,
    output logic             err_f
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic             stopped;
    logic             load_any;
    logic [CNT_W-1:0] ceiling;

    assign load_any = load_stb | (idx_evt & idx_load_en);
    assign ceiling  = (bmode == BND_CLAMP || bmode == BND_MODULO) ? preset : CMAX;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            latch    <= '0;
            carry_f  <= 1'b0;
            borrow_f <= 1'b0;
            sign_f   <= 1'b0;
            up_f     <= 1'b1;
            idx_f    <= 1'b0;
            err_f    <= 1'b0;
            stopped  <= 1'b0;
        end else begin
            if (clr_stb) begin
                carry_f  <= 1'b0;
                borrow_f <= 1'b0;
                sign_f   <= 1'b0;
                idx_f    <= 1'b0;
                err_f    <= 1'b0;
            end
            if (stp.bad) err_f <= 1'b1;
            if (idx_evt) idx_f <= 1'b1;
            if (latch_stb) latch <= cnt;
            if (load_any) begin
                cnt     <= preset;
                stopped <= 1'b0;
            end else if ((stp.up || stp.dn) && !stopped) begin
                up_f <= stp.up;
                if (stp.up) begin
                    if (cnt >= ceiling) begin
                        carry_f <= 1'b1;
                        sign_f  <= 1'b0;
                        case (bmode)
                            BND_CLAMP:   cnt <= cnt;
                            BND_ONESHOT: begin
                                cnt     <= '0;
                                stopped <= 1'b1;
                            end
                            default:     cnt <= '0;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    if (cnt == '0) begin
                        borrow_f <= 1'b1;
                        sign_f   <= 1'b1;
                        case (bmode)
                            BND_CLAMP:   cnt <= cnt;
                            BND_MODULO:  cnt <= ceiling;
                            BND_ONESHOT: begin
                                cnt     <= CMAX;
                                stopped <= 1'b1;
                            end
                            default:     cnt <= CMAX;
                        endcase
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
        end
    end

    // R8: clamped mode holds at the ceiling
    a_r8_clamp_hold: assert property (@(posedge clk) disable iff (rst)
        (bmode == BND_CLAMP && stp.up && !load_any && !stopped && cnt >= preset)
        |=> $stable(cnt));

    // R10: modulo mode returns to zero past the preset
    a_r10_modulo_wrap: assert property (@(posedge clk) disable iff (rst)
        (bmode == BND_MODULO && stp.up && !load_any && !stopped && cnt == preset)
        |=> cnt == '0);

    // R9: a frozen one-shot count only moves on a load
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (stopped && !load_any) |=> $stable(cnt));

    // R11: load strobe takes the preset
    a_r11_load: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> cnt == $past(preset));

    // R14: illegal transition is recorded
    a_r14_err_set: assert property (@(posedge clk) disable iff (rst)
        stp.bad |=> err_f);
endmodule

// File: rtl/quad_count_core.sv
module quad_count_core
    import qc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [1:0]       dec_sel,
    input  logic [1:0]       cnt_sel,
    input  logic             ab_en,
    input  logic             idx_preset_n,
    input  logic             idx_sync_req,
    input  logic             idx_pos_pol,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             load_stb,
    input  logic             latch_stb,
    input  logic             clr_stb,
    output logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] latch_val,
    output logic             carry_flag,
    output logic             borrow_flag,
    output logic             cmp_flag,
    output logic             sign_flag,
    output logic             up_flag,
    output logic             idx_flag,
    output logic             err_flag
);
    localparam int NIN = 3;

    logic [NIN-1:0] cur, prv;
    dec_mode_e      dec;
    bnd_mode_e      bmode;
    step_t          stp;
    logic           idx_evt;

    assign dec   = dec_mode_e'(dec_sel);
    assign bmode = bnd_mode_e'(cnt_sel);

    qc_sync #(.WIDTH(NIN)) u_sync (
        .clk (clk),
        .raw ({enc_idx, enc_b, enc_a}),
        .cur (cur),
        .prv (prv)
    );

    qc_decode u_dec (
        .a_s  (cur[0]),
        .b_s  (cur[1]),
        .a_d  (prv[0]),
        .b_d  (prv[1]),
        .dec  (dec),
        .gate (ab_en),
        .stp  (stp)
    );

    qc_index u_idx (
        .idx_s    (cur[2]),
        .idx_d    (prv[2]),
        .a_s      (cur[0]),
        .b_s      (cur[1]),
        .a_d      (prv[0]),
        .b_d      (prv[1]),
        .pos_pol  (idx_pos_pol),
        .sync_req (idx_sync_req),
        .dec      (dec),
        .evt      (idx_evt)
    );

    qc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .bmode       (bmode),
        .preset      (preset_val),
        .stp         (stp),
        .load_stb    (load_stb),
        .idx_evt     (idx_evt),
        .idx_load_en (~idx_preset_n),
        .latch_stb   (latch_stb),
        .clr_stb     (clr_stb),
        .cnt         (count_val),
        .latch       (latch_val),
        .carry_f     (carry_flag),
        .borrow_f    (borrow_flag),
        .sign_f      (sign_flag),
        .up_f        (up_flag),
        .idx_f       (idx_flag),
        .err_f       (err_flag)
    );

    assign cmp_flag = (count_val == preset_val);

    // R6: with phases gated off and no load, the count does not move
    a_r6_gate_off: assert property (@(posedge clk) disable iff (rst)
        (!ab_en && !load_stb && !(idx_evt && !idx_preset_n)) |=> $stable(count_val));
endmodule

// File: tb/tb_quad_count_core.sv
module tb_quad_count_core;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_a = 0, enc_b = 0, enc_idx = 1;
    logic [1:0] dec_sel = 0, cnt_sel = 0;
    logic ab_en = 1, idx_preset_n = 1, idx_sync_req = 0, idx_pos_pol = 0;
    logic [W-1:0] preset_val = 0;
    logic load_stb = 0, latch_stb = 0, clr_stb = 0;
    logic [W-1:0] count_val, latch_val;
    logic carry_flag, borrow_flag, cmp_flag, sign_flag, up_flag, idx_flag, err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    quad_count_core dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .dec_sel(dec_sel), .cnt_sel(cnt_sel), .ab_en(ab_en),
        .idx_preset_n(idx_preset_n), .idx_sync_req(idx_sync_req),
        .idx_pos_pol(idx_pos_pol), .preset_val(preset_val),
        .load_stb(load_stb), .latch_stb(latch_stb), .clr_stb(clr_stb),
        .count_val(count_val), .latch_val(latch_val), .carry_flag(carry_flag),
        .borrow_flag(borrow_flag), .cmp_flag(cmp_flag), .sign_flag(sign_flag),
        .up_flag(up_flag), .idx_flag(idx_flag), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n = 4);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ab(input logic a, input logic b);
        enc_a = a;
        enc_b = b;
        settle();
    endtask

    task automatic pulse_load();
        load_stb = 1; @(negedge clk); load_stb = 0; settle(2);
    endtask

    task automatic pulse_clr();
        clr_stb = 1; @(negedge clk); clr_stb = 0; settle(2);
    endtask

    task automatic fwd_cycle();
        set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    endtask

    task automatic bwd_cycle();
        set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    endtask

    // Expected count change for one input move, from R2..R5 and R14
    function automatic int exp_delta(input logic [1:0] d, input logic oa, input logic ob,
                                     input logic na, input logic nb);
        logic ar, af, br, bf;
        ar = !oa && na; af = oa && !na; br = !ob && nb; bf = ob && !nb;
        if (d == 2'd0) return ar ? (nb ? 1 : -1) : 0;
        if ((oa != na) && (ob != nb)) return 0;
        if (d == 2'd1) return (ar && !nb) ? 1 : ((af && !nb) ? -1 : 0);
        if (ar) return nb ? -1 : 1;
        if (af) return nb ? 1 : -1;
        if (d == 2'd3 && br) return na ? 1 : -1;
        if (d == 2'd3 && bf) return na ? -1 : 1;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        logic [1:0] ph [4];
        int pos;
        ph[0] = 2'b00; ph[1] = 2'b10; ph[2] = 2'b11; ph[3] = 2'b01;
        void'($urandom(32'd20240611));

        settle(5);
        rst = 0;
        settle(2);
        // R1 reset state
        chk("R1 count", count_val, 0);
        chk("R1 flags", {carry_flag, borrow_flag, sign_flag, idx_flag, err_flag}, 0);
        chk("R1 up_flag", up_flag, 1);

        // R2 step/direction
        set_ab(0, 1);
        set_ab(1, 1); chk("R2 rise up", count_val, 1);
        set_ab(0, 1); chk("R2 fall ignored", count_val, 1);
        set_ab(0, 0);
        set_ab(1, 0); chk("R2 rise down", count_val, 0);
        set_ab(0, 0);
        set_ab(1, 0);
        chk("R7 underflow wrap", count_val, 24'hFFFFFF);
        chk("R7 borrow+sign", {borrow_flag, sign_flag}, 2'b11);
        set_ab(0, 0); set_ab(0, 1);
        set_ab(1, 1);
        chk("R7 overflow wrap", count_val, 0);
        chk("R7 carry, sign cleared", {carry_flag, sign_flag}, 2'b10);
        set_ab(0, 1); set_ab(0, 0);
        chk("R2 B change ignored", count_val, 0);
        pulse_clr();
        chk("R14 clear flags", {carry_flag, borrow_flag, sign_flag}, 0);

        // R11 load and compare
        preset_val = 100;
        pulse_load();
        chk("R11 load", count_val, 100);
        chk("R11 cmp equal", cmp_flag, 1);
        preset_val = 50; settle(1);
        chk("R11 cmp differ", cmp_flag, 0);
        preset_val = 100;

        dec_sel = 1;
        fwd_cycle(); chk("R3 x1 fwd", count_val, 101);
        bwd_cycle(); chk("R3 x1 bwd", count_val, 100);
        dec_sel = 2;
        fwd_cycle(); chk("R4 x2 fwd", count_val, 102);
        bwd_cycle(); chk("R4 x2 bwd", count_val, 100);
        dec_sel = 3;
        fwd_cycle(); chk("R5 x4 fwd", count_val, 104);
        chk("R5 up_flag up", up_flag, 1);
        bwd_cycle(); chk("R5 x4 bwd", count_val, 100);
        chk("R5 up_flag down", up_flag, 0);

        // R14 illegal transition
        set_ab(1, 1);
        chk("R14 err set", err_flag, 1);
        chk("R14 no count", count_val, 100);
        set_ab(0, 0);
        pulse_clr();
        chk("R14 err cleared", err_flag, 0);

        // R6 gate
        ab_en = 0;
        fwd_cycle(); chk("R6 gated", count_val, 100);
        ab_en = 1;

        latch_stb = 1; @(negedge clk); latch_stb = 0; settle(2);
        chk("R11 latch", latch_val, 100);

        // R8 clamped
        cnt_sel = 1; preset_val = 102;
        fwd_cycle();
        chk("R8 hold at ceiling", count_val, 102);
        chk("R8 carry", carry_flag, 1);
        preset_val = 2; pulse_load();
        bwd_cycle();
        chk("R8 hold at zero", count_val, 0);
        chk("R8 borrow", borrow_flag, 1);

        // R10 modulo
        pulse_clr();
        cnt_sel = 3;
        fwd_cycle();
        chk("R10 fwd wrap", count_val, 1);
        chk("R10 carry", carry_flag, 1);
        bwd_cycle();
        chk("R10 bwd wrap", count_val, 0);
        chk("R10 borrow", borrow_flag, 1);

        // R9 one-shot
        pulse_clr();
        cnt_sel = 2; preset_val = 24'hFFFFFE; pulse_load();
        fwd_cycle();
        chk("R9 frozen after wrap", count_val, 0);
        chk("R9 carry", carry_flag, 1);
        preset_val = 5; pulse_load();
        fwd_cycle();
        chk("R9 resumes after load", count_val, 9);

        // R12 edge index
        cnt_sel = 0; idx_preset_n = 0; idx_pos_pol = 0; preset_val = 24'h123;
        pulse_clr();
        enc_idx = 0; settle();
        chk("R12 falling loads", count_val, 24'h123);
        chk("R12 idx flag", idx_flag, 1);
        pulse_clr();
        preset_val = 24'h200;
        enc_idx = 1; settle();
        chk("R12 inactive edge", count_val, 24'h123);
        chk("R12 no flag", idx_flag, 0);
        idx_pos_pol = 1;
        enc_idx = 0; settle();
        enc_idx = 1; settle();
        chk("R12 rising loads", count_val, 24'h200);
        idx_preset_n = 1; preset_val = 24'h300; pulse_clr();
        enc_idx = 0; settle(); enc_idx = 1; settle();
        chk("R12 flag only", {idx_flag, count_val}, {1'b1, 24'h200});

        // R13 synchronous index, load against coincident step
        idx_preset_n = 0; idx_sync_req = 1; preset_val = 24'h40;
        set_ab(1, 0); chk("R13 step before", count_val, 24'h201);
        set_ab(1, 1); chk("R13 sync load beats step", count_val, 24'h40);
        set_ab(0, 1); chk("R13 counts on", count_val, 24'h41);
        enc_idx = 0; settle();
        set_ab(0, 0); set_ab(1, 0); set_ab(1, 1);
        chk("R13 inactive level", count_val, 24'h44);
        dec_sel = 0; preset_val = 24'h77;
        enc_idx = 1; settle();
        chk("R13 forced edge mode", count_val, 24'h77);
        set_ab(0, 1); set_ab(0, 0);
        chk("R2 no count on falls", count_val, 24'h77);

        // Random walk across quadrature schemes, R3..R5 and R7
        idx_sync_req = 0; idx_preset_n = 1; preset_val = 24'h10;
        pulse_load();
        model = 24'h10;
        pos = 0;
        for (int i = 0; i < 300; i++) begin
            logic [1:0] d;
            int nxt, dl;
            d = 2'($urandom_range(1, 3));
            dec_sel = d;
            nxt = ($urandom_range(0, 1) == 1) ? (pos + 1) % 4 : (pos + 3) % 4;
            dl = exp_delta(d, ph[pos][1], ph[pos][0], ph[nxt][1], ph[nxt][0]);
            model = model + W'(dl);
            set_ab(ph[nxt][1], ph[nxt][0]);
            pos = nxt;
            chk("R5 random walk", count_val, model);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule